// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software with a down counter that a slow tick pulse decrements. Software keeps the system alive by sending a keyed restart command, but only inside a permitted window: a restart while the counter is still above a programmed delta threshold counts as a fault, just as letting the counter run out does. A configuration word sets the reload value, the window threshold, the fault actions and the halt conditions. It is accepted once after reset and then frozen until the next reset, so runaway code cannot reconfigure or silence the watchdog.

A fault sets a sticky flag in a status word, which clears when read. It can raise a level interrupt, start a fixed-length reset pulse on a system-reset or a core-only-reset output, or do both. Two halt inputs, one for an idle condition and one for debug, can each be set to freeze the counter.

The counter runs a small state machine with three states. CS_RUN decrements on each tick. CS_HOLD freezes the count while an enabled halt input is high. CS_OFF freezes the count and ignores restarts while the disable bit is set. The state follows the mode and the halt inputs with one register stage, so a halt takes effect from the cycle after it is sampled. The reset generator has two states. RS_IDLE moves to RS_DRIVE on a fault when the reset enable is set. RS_DRIVE holds the selected reset output for RST_CYCLES clock cycles and then returns to RS_IDLE. Faults that arrive while in RS_DRIVE do not extend the pulse.

Top module: `wdog_window_top`

## Requirements
- R1: After reset, the mode word reads 0x3FFF2FFF, the status word reads 0, and irq_o, rst_sys_o and rst_core_o are low.
- R2: Only the first mode write (address 1) after reset is accepted, with bits 31:30 stored as zero. Every later mode write leaves the mode word and the counter unchanged.
- R3: The counter decrements once per tick. Reload value L sits in mode bits 11:0, and an accepted mode write loads the counter with its L. The (L+1)-th tick after a load sets status bit 0 (underflow) and reloads the counter with L.
- R4: A write to address 0 with 0xA5 in bits 31:24 and bit 0 set reloads the counter with L. A write with any other key, or with bit 0 clear, has no effect.
- R5: A restart while the counter is above the delta value D (mode bits 27:16) sets status bit 1 (window error). A restart at or below D sets nothing. In both cases the counter is reloaded.
- R6: While mode bit 15 (disable) is set, the counter holds, no fault is raised and restarts are ignored.
- R7: With mode bit 29 set, the counter holds while idle_i is high. With mode bit 28 set, it holds while debug_i is high. With a bit clear, its input has no effect.
- R8: A read of address 2 returns {30'b0, window error, underflow} on the next cycle and clears both flags, except a flag whose fault occurs in the read cycle itself.
- R9: irq_o is high while either status flag is set and mode bit 12 (interrupt enable) is set.
- R10: With mode bit 13 set, a fault drives a reset output high for RST_CYCLES cycles starting the cycle after the fault. The pulse goes to rst_core_o when mode bit 14 is set and to rst_sys_o otherwise.
- R11: A read of address 1 returns the mode word. A read of address 0 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per counter tick |
| idle_i | input | 1 | Idle indication, halts the counter when enabled |
| debug_i | input | 1 | Debug indication, halts the counter when enabled |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address: 0 control, 1 mode, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_o | output | 1 | Fault interrupt level |
| rst_sys_o | output | 1 | System reset pulse |
| rst_core_o | output | 1 | Core-only reset pulse |

## Verification
The count itself cannot be read at the ports, so a wrong count shows up as a shift in timing. An underflow that arrives a tick early or late moves irq_o and status bit 0 by exactly one tick. A wrong comparison against the delta shows up as a flipped window-error bit on the very next status read. A stale counter state means a halt or disable that fails to freeze the count, which moves the interrupt by as many ticks as were let through. A wrong reset-generator state lengthens or shortens the reset pulse by whole cycles, and this is visible at the first clock edge where the pulse ends.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
    typedef enum logic [1:0] {CS_RUN, CS_HOLD, CS_OFF} cnt_state_e;
    typedef enum logic {RS_IDLE, RS_DRIVE} rst_state_e;

    localparam logic [1:0]  ADDR_CTRL = 2'd0;
    localparam logic [1:0]  ADDR_MODE = 2'd1;
    localparam logic [1:0]  ADDR_STAT = 2'd2;

    localparam logic [31:0] MODE_RESET = 32'h3FFF_2FFF;
    localparam logic [31:0] MODE_MASK  = 32'h3FFF_FFFF;

    localparam int unsigned DELTA_LSB     = 16;
    localparam int unsigned BIT_IRQ_EN    = 12;
    localparam int unsigned BIT_RST_EN    = 13;
    localparam int unsigned BIT_CORE_ONLY = 14;
    localparam int unsigned BIT_DISABLE   = 15;
    localparam int unsigned BIT_DBG_HALT  = 28;
    localparam int unsigned BIT_IDLE_HALT = 29;

    localparam logic [7:0]  CTRL_KEY = 8'hA5;
endpackage

// File: rtl/wdw_regs.sv
module wdw_regs
    import wdw_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             unf_evt,
    input  logic             err_evt,
    output logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] delta_val,
    output logic             load_pulse,
    output logic [CNT_W-1:0] load_val,
    output logic             restart_req,
    output logic             dis_bit,
    output logic             idle_halt,
    output logic             dbg_halt,
    output logic             rst_en,
    output logic             core_only,
    output logic             irq_o
);
    logic [31:0] mode_q;
    logic        locked_q;
    logic        unf_q, err_q;
    logic        wr_mode, rd_stat;

    assign wr_mode     = bus_wr && (bus_addr == ADDR_MODE) && !locked_q;
    assign restart_req = bus_wr && (bus_addr == ADDR_CTRL)
                         && (bus_wdata[31:24] == CTRL_KEY) && bus_wdata[0];
    assign rd_stat     = bus_rd && (bus_addr == ADDR_STAT);

    assign load_pulse = wr_mode;
    assign load_val   = bus_wdata[CNT_W-1:0];
    assign reload_val = mode_q[CNT_W-1:0];
    assign delta_val  = mode_q[DELTA_LSB +: CNT_W];
    assign dis_bit    = mode_q[BIT_DISABLE];
    assign idle_halt  = mode_q[BIT_IDLE_HALT];
    assign dbg_halt   = mode_q[BIT_DBG_HALT];
    assign rst_en     = mode_q[BIT_RST_EN];
    assign core_only  = mode_q[BIT_CORE_ONLY];

    // one-shot configuration word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_RESET;
            locked_q <= 1'b0;
        end else if (wr_mode) begin
            mode_q   <= bus_wdata & MODE_MASK;
            locked_q <= 1'b1;
        end
    end

    // sticky fault flags, cleared by a status read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unf_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (unf_evt)      unf_q <= 1'b1;
            else if (rd_stat) unf_q <= 1'b0;
            if (err_evt)      err_q <= 1'b1;
            else if (rd_stat) err_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (bus_addr)
                ADDR_MODE: bus_rdata <= mode_q;
                ADDR_STAT: bus_rdata <= {30'b0, err_q, unf_q};
                default:   bus_rdata <= '0;
            endcase
        end
    end

    assign irq_o = mode_q[BIT_IRQ_EN] && (unf_q || err_q);

    assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> $stable(mode_q));

    assert_stat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !unf_evt && !err_evt) |=> (!unf_q && !err_q));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((unf_evt || err_evt) && mode_q[BIT_IRQ_EN]) |=> irq_o);
endmodule

// File: rtl/wdw_counter.sv
module wdw_counter
    import wdw_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             idle_i,
    input  logic             debug_i,
    input  logic             dis_bit,
    input  logic             idle_halt,
    input  logic             dbg_halt,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] delta_val,
    input  logic             load_pulse,
    input  logic [CNT_W-1:0] load_val,
    input  logic             restart_req,
    output logic             unf_evt,
    output logic             err_evt
);
    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             restart_ok, halted;

    assign halted = (idle_i && idle_halt) || (debug_i && dbg_halt);

    always_comb begin
        if (dis_bit)     state_d = CS_OFF;
        else if (halted) state_d = CS_HOLD;
        else             state_d = CS_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_RUN;
        else        state_q <= state_d;
    end

    // fault events from the current state
    always_comb begin
        restart_ok = 1'b0;
        unf_evt    = 1'b0;
        err_evt    = 1'b0;
        unique case (state_q)
            CS_RUN: begin
                restart_ok = restart_req;
                err_evt    = restart_req && (cnt_q > delta_val);
                unf_evt    = tick_i && !restart_req && !load_pulse
                             && (cnt_q == '0);
            end
            CS_HOLD: begin
                restart_ok = restart_req;
                err_evt    = restart_req && (cnt_q > delta_val);
            end
            CS_OFF: begin
                restart_ok = 1'b0;
            end
            default: begin
                restart_ok = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (load_pulse) begin
            cnt_q <= load_val;
        end else if (restart_ok) begin
            cnt_q <= reload_val;
        end else if (state_q == CS_RUN && tick_i) begin
            if (cnt_q == '0) cnt_q <= reload_val;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_unf_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        unf_evt |=> (cnt_q == $past(reload_val)));

    assert_off_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_OFF) |-> (!unf_evt && !err_evt));

    assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_HOLD && !restart_req && !load_pulse) |=> $stable(cnt_q));
endmodule

// File: rtl/wdw_rstgen.sv
module wdw_rstgen
    import wdw_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_evt,
    input  logic rst_en,
    input  logic core_only,
    output logic rst_sys_o,
    output logic rst_core_o
);
    localparam int unsigned LEN_W = $clog2(RST_CYCLES + 1);
    localparam logic [LEN_W-1:0] LEN_INIT = LEN_W'(RST_CYCLES - 1);

    rst_state_e       state_q;
    logic [LEN_W-1:0] len_q;
    logic             core_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            len_q   <= '0;
            core_q  <= 1'b0;
        end else begin
            unique case (state_q)
                RS_IDLE: begin
                    if (fault_evt && rst_en) begin
                        state_q <= RS_DRIVE;
                        len_q   <= LEN_INIT;
                        core_q  <= core_only;
                    end
                end
                RS_DRIVE: begin
                    if (len_q == '0) state_q <= RS_IDLE;
                    else             len_q   <= len_q - 1'b1;
                end
                default: state_q <= RS_IDLE;
            endcase
        end
    end

    always_comb begin
        rst_sys_o  = 1'b0;
        rst_core_o = 1'b0;
        unique case (state_q)
            RS_DRIVE: begin
                rst_sys_o  = !core_q;
                rst_core_o = core_q;
            end
            default: begin
                rst_sys_o  = 1'b0;
                rst_core_o = 1'b0;
            end
        endcase
    end

    assert_rst_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_evt && rst_en && state_q == RS_IDLE) |=> (rst_sys_o || rst_core_o));

    assert_rst_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_sys_o && rst_core_o));
endmodule

// File: rtl/wdog_window_top.sv
module wdog_window_top
    import wdw_pkg::*;
#(
    parameter int unsigned CNT_W      = 12,
    parameter int unsigned RST_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        idle_i,
    input  logic        debug_i,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o,
    output logic        rst_sys_o,
    output logic        rst_core_o
);
    logic [CNT_W-1:0] reload_val, delta_val, load_val;
    logic load_pulse, restart_req, dis_bit, idle_halt, dbg_halt;
    logic rst_en, core_only, unf_evt, err_evt;

    wdw_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .unf_evt(unf_evt), .err_evt(err_evt),
        .reload_val(reload_val), .delta_val(delta_val),
        .load_pulse(load_pulse), .load_val(load_val),
        .restart_req(restart_req), .dis_bit(dis_bit),
        .idle_halt(idle_halt), .dbg_halt(dbg_halt),
        .rst_en(rst_en), .core_only(core_only), .irq_o(irq_o)
    );

    wdw_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n),
        .tick_i(tick_i), .idle_i(idle_i), .debug_i(debug_i),
        .dis_bit(dis_bit), .idle_halt(idle_halt), .dbg_halt(dbg_halt),
        .reload_val(reload_val), .delta_val(delta_val),
        .load_pulse(load_pulse), .load_val(load_val),
        .restart_req(restart_req),
        .unf_evt(unf_evt), .err_evt(err_evt)
    );

    wdw_rstgen #(.RST_CYCLES(RST_CYCLES)) rst_i (
        .clk(clk), .rst_n(rst_n),
        .fault_evt(unf_evt || err_evt),
        .rst_en(rst_en), .core_only(core_only),
        .rst_sys_o(rst_sys_o), .rst_core_o(rst_core_o)
    );
endmodule

// File: tb/wdog_window_top_tb_top.sv
`timescale 1ns/1ps
module wdog_window_top_tb_top;
    localparam int RSTC = 8;
    localparam logic [31:0] KEYGO = 32'hA500_0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0, idle_i = 1'b0, debug_i = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq_o, rst_sys_o, rst_core_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdog_window_top #(.CNT_W(12), .RST_CYCLES(RSTC)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .idle_i(idle_i),
        .debug_i(debug_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .rst_sys_o(rst_sys_o), .rst_core_o(rst_core_o)
    );

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; idle_i = 1'b0; debug_i = 1'b0; tick_i = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        step();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tick();
        tick_i = 1'b1;
        step();
        tick_i = 1'b0;
    endtask

    task automatic ticks_quiet(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            tick();
            chk(irq_o == 1'b0, req, {31'b0, irq_o}, 32'd0);
        end
    endtask

    function automatic logic [31:0] mode_word(input int l, input int d,
                                              input logic [31:0] flags);
        return 32'(l) | (32'(d) << 16) | flags;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        bit exp_err;

        // R1 reset state and R11 readback of control
        do_reset();
        chk(irq_o == 0 && rst_sys_o == 0 && rst_core_o == 0, "R1 outputs",
            {29'b0, irq_o, rst_sys_o, rst_core_o}, 32'd0);
        rd(2'd1, d); chk(d == 32'h3FFF_2FFF, "R1 mode reset", d, 32'h3FFF_2FFF);
        rd(2'd2, d); chk(d == 32'd0, "R1 status reset", d, 32'd0);
        rd(2'd0, d); chk(d == 32'd0, "R11 control reads zero", d, 32'd0);

        // R2 one-shot mode write, upper bits masked
        wr(2'd1, 32'hC000_1003);
        rd(2'd1, d); chk(d == 32'h0000_1003, "R2/R11 first write", d, 32'h0000_1003);
        wr(2'd1, 32'h0000_1007);
        rd(2'd1, d); chk(d == 32'h0000_1003, "R2 second write ignored", d, 32'h0000_1003);
        ticks_quiet(3, "R2 reload unchanged");
        tick(); chk(irq_o == 1'b1, "R2 underflow at old reload", {31'b0, irq_o}, 32'd1);

        // R3 and R9 underflow timing sweep
        for (int l = 0; l <= 6; l++) begin
            do_reset();
            wr(2'd1, mode_word(l, l, 32'h1000));
            ticks_quiet(l, "R3 before underflow");
            tick();
            chk(irq_o == 1'b1, "R3/R9 underflow irq", {31'b0, irq_o}, 32'd1);
            rd(2'd2, d); chk(d == 32'd1, "R3 status underflow", d, 32'd1);
            chk(irq_o == 1'b0, "R8/R9 irq clears after read", {31'b0, irq_o}, 32'd0);
            ticks_quiet(l, "R3 reload after underflow");
            tick();
            chk(irq_o == 1'b1, "R3 second underflow", {31'b0, irq_o}, 32'd1);
        end

        // R9 interrupt enable clear: flag set but irq stays low
        do_reset();
        wr(2'd1, mode_word(0, 0, 32'h0));
        tick();
        chk(irq_o == 1'b0, "R9 irq gated off", {31'b0, irq_o}, 32'd0);
        rd(2'd2, d); chk(d == 32'd1, "R9 flag still set", d, 32'd1);

        // R5 window sweep
        for (int l = 0; l <= 5; l++) begin
            for (int dl = 0; dl <= 5; dl++) begin
                for (int k = 0; k <= l; k++) begin
                    do_reset();
                    wr(2'd1, mode_word(l, dl, 32'h1000));
                    for (int t = 0; t < k; t++) tick();
                    wr(2'd0, KEYGO);
                    exp_err = ((l - k) > dl);
                    chk(irq_o == exp_err, "R5 window irq", {31'b0, irq_o}, {31'b0, exp_err});
                    rd(2'd2, d);
                    chk(d == (exp_err ? 32'd2 : 32'd0), "R5 window status", d,
                        exp_err ? 32'd2 : 32'd0);
                end
            end
        end

        // R4 key check and reload
        do_reset();
        wr(2'd1, mode_word(3, 0, 32'h1000));
        tick(); tick();
        wr(2'd0, 32'h5A00_0001);
        wr(2'd0, 32'hA500_0000);
        rd(2'd2, d); chk(d == 32'd0, "R4 bad writes no error", d, 32'd0);
        tick();
        tick(); chk(irq_o == 1'b1, "R4 bad writes did not reload", {31'b0, irq_o}, 32'd1);
        rd(2'd2, d);
        ticks_quiet(3, "R4 after underflow");
        wr(2'd0, KEYGO);
        rd(2'd2, d); chk(d == 32'd0, "R4 legal restart no fault", d, 32'd0);
        ticks_quiet(3, "R4 restart reloaded");
        tick(); chk(irq_o == 1'b1, "R4 underflow after restart", {31'b0, irq_o}, 32'd1);

        // R6 disable
        do_reset();
        wr(2'd1, mode_word(2, 0, 32'h9000));
        ticks_quiet(10, "R6 disabled no underflow");
        wr(2'd0, KEYGO);
        rd(2'd2, d); chk(d == 32'd0, "R6 restart ignored", d, 32'd0);

        // R7 idle halt
        do_reset();
        wr(2'd1, mode_word(2, 2, 32'h2000_1000));
        idle_i = 1'b1; step();
        ticks_quiet(10, "R7 idle halt");
        idle_i = 1'b0; step();
        ticks_quiet(2, "R7 resume");
        tick(); chk(irq_o == 1'b1, "R7 underflow after idle", {31'b0, irq_o}, 32'd1);
        // R7 debug halt
        do_reset();
        wr(2'd1, mode_word(2, 2, 32'h1000_1000));
        debug_i = 1'b1; step();
        ticks_quiet(10, "R7 debug halt");
        debug_i = 1'b0; step();
        ticks_quiet(2, "R7 resume dbg");
        tick(); chk(irq_o == 1'b1, "R7 underflow after debug", {31'b0, irq_o}, 32'd1);
        // R7 halt bits clear: inputs have no effect
        do_reset();
        wr(2'd1, mode_word(2, 2, 32'h1000));
        idle_i = 1'b1; debug_i = 1'b1; step();
        ticks_quiet(2, "R7 no halt");
        tick(); chk(irq_o == 1'b1, "R7 inputs ignored", {31'b0, irq_o}, 32'd1);
        idle_i = 1'b0; debug_i = 1'b0;

        // R8 read in the same cycle as a fault
        do_reset();
        wr(2'd1, mode_word(0, 0, 32'h1000));
        tick();
        bus_rd = 1'b1; bus_addr = 2'd2; tick_i = 1'b1;
        step();
        bus_rd = 1'b0; tick_i = 1'b0;
        chk(bus_rdata == 32'd1, "R8 read data", bus_rdata, 32'd1);
        rd(2'd2, d); chk(d == 32'd1, "R8 flag kept by same-cycle fault", d, 32'd1);
        rd(2'd2, d); chk(d == 32'd0, "R8 cleared", d, 32'd0);

        // R10 system reset pulse
        do_reset();
        wr(2'd1, mode_word(1, 1, 32'h2000));
        tick();
        chk(rst_sys_o == 1'b0, "R10 no early pulse", {31'b0, rst_sys_o}, 32'd0);
        tick();
        chk(rst_sys_o == 1'b1 && rst_core_o == 1'b0, "R10 sys pulse start",
            {30'b0, rst_sys_o, rst_core_o}, 32'd2);
        for (int i = 1; i < RSTC; i++) begin
            step();
            chk(rst_sys_o == 1'b1, "R10 sys pulse held", {31'b0, rst_sys_o}, 32'd1);
        end
        step();
        chk(rst_sys_o == 1'b0, "R10 sys pulse end", {31'b0, rst_sys_o}, 32'd0);

        // R10 core-only reset pulse from an early restart
        do_reset();
        wr(2'd1, mode_word(3, 0, 32'h6000));
        wr(2'd0, KEYGO);
        chk(rst_core_o == 1'b1 && rst_sys_o == 1'b0, "R10 core pulse start",
            {30'b0, rst_sys_o, rst_core_o}, 32'd1);
        for (int i = 1; i < RSTC; i++) begin
            step();
            chk(rst_core_o == 1'b1, "R10 core pulse held", {31'b0, rst_core_o}, 32'd1);
        end
        step();
        chk(rst_core_o == 1'b0, "R10 core pulse end", {31'b0, rst_core_o}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule